// File: doc/BRIEF.md
# Clocked-Slave Serial Word Receiver

This block receives serial words whose shift clock is supplied by an external master. The clock and data lines are brought into the system clock domain through a short flip-flop chain. Each rising edge of the synchronised clock takes one data bit, least significant bit first. Once a word of 8 or 9 bits has been assembled, it is copied into a holding register and a completion flag is raised. An interrupt request can follow that flag.

Software reaches the block through a small register port. The port has a receive control/status register, a receive data register, a mode register that carries the synchronous-mode and clock-source selects, and an interrupt enable register. Reception runs only when the mode bits select synchronous slave operation and continuous receive is enabled. A word that completes while the previous one is still unread is an overrun. The overrun flag stops reception, and software clears it by dropping the continuous-receive bit. Reads return data one cycle after the request.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, the register at address 0 (receive control) reads 0x00, address 1 (data) reads 0x00, address 2 (mode) reads 0x02, address 3 (interrupt) reads 0x00, and `irq` is 0.
- R2: A word is received only when all of these hold: receive-control bit 7 (port enable) is 1, receive-control bit 4 (continuous receive) is 1, mode bit 4 (synchronous) is 1, and mode bit 7 (clock source is internal) is 0.
- R3: Receive-control bit 5 (single receive) has no effect. With bit 5 set and bit 4 clear, no word is received.
- R4: Data is sampled on rising edges of `sck`, least significant bit first. After 8 edges with receive-control bit 6 clear, the byte appears at address 1 and interrupt-register bit 1 (word ready) becomes 1.
- R5: With receive-control bit 6 set, a word is 9 bits long. Its ninth bit is shown in receive-control bit 0 and its low 8 bits at address 1.
- R6: `irq` is 1 only while the word-ready flag is set and interrupt-register bit 0 (enable) is 1. It follows the flag one cycle later.
- R7: Reading address 1 clears the word-ready flag.
- R8: A word that completes while the word-ready flag is set raises receive-control bit 1 (overrun). That word is dropped, the held data is kept, and later words are ignored while the overrun flag stays set.
- R9: Writing receive-control with bit 4 = 0 clears the overrun flag.
- R10: Clearing port enable discards a partly received word, so the next word starts from bit 0.
- R11: Mode bit 1 always reads 1 and mode bit 3 always reads 0, whatever is written. Receive-control bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Shift clock from the external master |
| sdat | input | 1 | Serial data line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
A bit counter that has slipped shows up as a wrong byte at address 1 after the very next word. It can also show up as a missing or early word-ready flag, visible within a few cycles of the last clock edge. A stale overrun or ready flag shows at the ports on the next register read, where later words are either lost or overwrite unread data. Checking the held data after each overrun or mode change exposes state that leaked from an earlier word.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_RXCTL = 2'd0;
  localparam logic [REG_AW-1:0] A_RXDAT = 2'd1;
  localparam logic [REG_AW-1:0] A_MODE  = 2'd2;
  localparam logic [REG_AW-1:0] A_IEN   = 2'd3;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic sd,
  output logic rise,
  output logic sd_s
);
  logic [STAGES-1:0] ck_chain;
  logic [STAGES-1:0] dt_chain;
  logic              ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_chain <= '0;
      dt_chain <= '0;
      ck_prev  <= 1'b0;
    end else begin
      ck_chain <= {ck_chain[STAGES-2:0], sck};
      dt_chain <= {dt_chain[STAGES-2:0], sd};
      ck_prev  <= ck_chain[STAGES-1];
    end
  end

  assign rise = ck_chain[STAGES-1] & ~ck_prev;
  assign sd_s = dt_chain[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int MAX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             nine,
  input  logic             rise,
  input  logic             bit_in,
  output logic             done,
  output logic [MAX_W-1:0] word
);
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [MAX_W-1:0] sr, sr_nx;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = nine ? CNT_W'(MAX_W - 1) : CNT_W'(MAX_W - 2);

  always_comb begin
    sr_nx      = sr;
    sr_nx[cnt] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      done <= 1'b0;
      if (rst) begin
        sr   <= '0;
        word <= '0;
      end
    end else begin
      done <= 1'b0;
      if (rise) begin
        sr <= sr_nx;
        if (cnt == last_idx) begin
          word <= sr_nx;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_W - 1));
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sck,
  input  logic                        sdat,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [sync_rx_pkg::REG_AW-1:0] addr,
  input  logic [7:0]                  wdata,
  output logic [7:0]                  rdata,
  output logic                        irq
);
  import sync_rx_pkg::*;
  localparam int MAX_W = DATA_W + 1;

  logic port_en, nine_sel, single_en, cont_en, adr_det, ovf, bit9;
  logic clk_int, md6, md5, sync_md, md2, md0;
  logic rie, rx_ready;
  logic [DATA_W-1:0] rx_data;

  logic rise, sd_s, sh_done;
  logic [MAX_W-1:0] sh_word;
  logic mode_ok, active, rd_hit, ov_evt, ctl_wr;

  assign mode_ok = port_en & sync_md & ~clk_int;
  assign active  = mode_ok & cont_en & ~ovf;
  assign rd_hit  = rd_en & (addr == A_RXDAT);
  assign ctl_wr  = wr_en & (addr == A_RXCTL);
  assign ov_evt  = sh_done & rx_ready & ~rd_hit;

  sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .sd(sdat), .rise(rise), .sd_s(sd_s)
  );

  rx_shifter #(.MAX_W(MAX_W)) u_shift (
    .clk(clk), .rst(rst), .en(active), .nine(nine_sel), .rise(rise),
    .bit_in(sd_s), .done(sh_done), .word(sh_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      {port_en, nine_sel, single_en, cont_en, adr_det} <= '0;
      ovf      <= 1'b0;
      bit9     <= 1'b0;
      {clk_int, md6, md5, sync_md, md2, md0} <= '0;
      rie      <= 1'b0;
      rx_ready <= 1'b0;
      rx_data  <= '0;
      rdata    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_RXCTL: {port_en, nine_sel, single_en, cont_en, adr_det} <= wdata[7:3];
          A_MODE:  {clk_int, md6, md5, sync_md, md2, md0} <=
                     {wdata[7:4], wdata[2], wdata[0]};
          A_IEN:   rie <= wdata[0];
          default: ;
        endcase
      end
      if (ctl_wr && !wdata[4]) ovf <= 1'b0;
      else if (ov_evt)          ovf <= 1'b1;

      if (rd_hit) rx_ready <= 1'b0;
      if (sh_done && !ov_evt) begin
        rx_data  <= sh_word[DATA_W-1:0];
        rx_ready <= 1'b1;
        if (nine_sel) bit9 <= sh_word[MAX_W-1];
      end

      irq <= rx_ready & rie;

      if (rd_en) begin
        case (addr)
          A_RXCTL: rdata <= {port_en, nine_sel, single_en, cont_en, adr_det, 1'b0, ovf, bit9};
          A_RXDAT: rdata <= 8'(rx_data);
          A_MODE:  rdata <= {clk_int, md6, md5, sync_md, 1'b0, md2, 1'b1, md0};
          default: rdata <= {6'b0, rx_ready, rie};
        endcase
      end
    end
  end

  // R2: a newly ready word must come from a cycle where slave reception was enabled
  a_r2_word_needs_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(active, 2));
  // R6: interrupt only follows an enabled, pending word
  a_r6_irq_qualified: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_ready && rie));
  // R8: no word completes while overrun blocks reception
  a_r8_ovf_blocks: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !sh_done);
  // R9: dropping continuous receive clears overrun
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wdata[4]) |=> !ovf);
endmodule

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb;
  logic clk = 0, rst = 1, sck = 0, sdat = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] r;

  always #10 clk = ~clk;

  sync_slave_rx u_dut (
    .clk(clk), .rst(rst), .sck(sck), .sdat(sdat), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {nine-bit mode, ninth bit, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'h5A},
    {1'b1, 1'b0, 8'h81}, {1'b0, 1'b0, 8'h00}, {1'b1, 1'b1, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic send_bits(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sdat = w[i];
      repeat (4) @(negedge clk); sck = 1;
      repeat (4) @(negedge clk); sck = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    // R1 reset values
    rd(0, r); chk(r == 8'h00, "R1 rxctl", r, 8'h00);
    rd(1, r); chk(r == 8'h00, "R1 data", r, 8'h00);
    rd(2, r); chk(r == 8'h02, "R1 mode", r, 8'h02);
    rd(3, r); chk(r == 8'h00, "R1 ien", r, 8'h00);
    chk(irq == 0, "R1 irq", irq, 0);

    // R11 constant bits
    wr(2, 8'hFF); rd(2, r); chk(r == 8'hF7, "R11 mode bits", r, 8'hF7);
    wr(0, 8'hFF); rd(0, r); chk(r[2] == 0, "R11 rxctl bit2", r[2], 0);
    wr(0, 8'h00);

    // R2: clock-source internal blocks reception
    wr(0, 8'h90);
    send_bits(9'h055, 8);
    rd(3, r); chk(r[1] == 0, "R2 internal clock blocks", r[1], 0);
    wr(2, 8'h00); send_bits(9'h055, 8);
    rd(3, r); chk(r[1] == 0, "R2 async blocks", r[1], 0);

    // R3: single receive alone does nothing
    wr(2, 8'h10); wr(0, 8'hA0);
    send_bits(9'h0C3, 8);
    rd(3, r); chk(r[1] == 0, "R3 single ignored", r[1], 0);

    // vector walk: R4, R5, R6, R7
    wr(3, 8'h01);
    foreach (VEC[k]) begin
      wr(0, VEC[k][9] ? 8'hD0 : 8'h90);
      send_bits(VEC[k][8:0], VEC[k][9] ? 9 : 8);
      chk(irq == 1, "R6 irq raised", irq, 1);
      rd(3, r); chk(r[1] == 1, "R4 ready set", r[1], 1);
      if (VEC[k][9]) begin
        rd(0, r); chk(r == (8'hD0 | {7'b0, VEC[k][8]}), "R5 ninth bit", r, 8'hD0 | {7'b0, VEC[k][8]});
      end
      rd(1, r); chk(r == VEC[k][7:0], VEC[k][9] ? "R5 data" : "R4 data", r, VEC[k][7:0]);
      rd(3, r); chk(r[1] == 0, "R7 read clears ready", r[1], 0);
      @(negedge clk); chk(irq == 0, "R6 irq drops", irq, 0);
    end

    // R6: enable off keeps irq low
    wr(3, 8'h00); wr(0, 8'h90);
    send_bits(9'h066, 8);
    rd(3, r); chk(r[1] == 1 && irq == 0, "R6 irq masked", irq, 0);
    rd(1, r);

    // R8 overrun
    send_bits(9'h011, 8);
    send_bits(9'h022, 8);
    rd(0, r); chk(r[1] == 1, "R8 overrun set", r[1], 1);
    send_bits(9'h033, 8);
    rd(1, r); chk(r == 8'h11, "R8 first word kept", r, 8'h11);
    send_bits(9'h044, 8);
    rd(3, r); chk(r[1] == 0, "R8 blocked while overrun", r[1], 0);
    // R9 clear
    wr(0, 8'h80); rd(0, r); chk(r[1] == 0, "R9 overrun cleared", r[1], 0);
    wr(0, 8'h90); send_bits(9'h077, 8);
    rd(1, r); chk(r == 8'h77, "R9 reception resumes", r, 8'h77);

    // R10 partial discard
    send_bits(9'h00F, 4);
    wr(0, 8'h10); wr(0, 8'h90);
    send_bits(9'h0B2, 8);
    rd(1, r); chk(r == 8'hB2, "R10 partial discarded", r, 8'hB2);

    summary();
  end
endmodule